// File: doc/BRIEF.md
# Three-Wire Serial Converter Reader

This block is the master side of a short serial read from an 8-bit analog-to-digital converter. The converters sit on three wires: a shared serial clock, a shared data line driven by the converter, and an active-low select line that each converter has to itself. The block sequences one complete read in hardware. On an accepted request it pulls the chosen select line low and gives one dummy clock that starts the conversion. It then gives eight clocks and takes one bit after each, most significant first. One more clock follows, the select line goes high again, and the block waits a fixed quiet time before it presents the byte with a one-cycle done strobe.

Several converters share the clock and data wires, and an index on the request picks which select line takes part. The speed of the serial clock is set by a parameter giving the length of each high and each low phase in system cycles. The quiet time after release is also a parameter. The analog side of the converter plays no part here.

Top module: `serial_adc_reader`

## Requirements
- R1: After synchronous reset, every select output is high, the serial clock is low, busy and done are low, and the result output is 0x00.
- R2: A request with an index below NUM_DEV, made while idle, drives select line number `index` low on the next cycle. No other select line is ever low, and all select lines are high whenever busy is low.
- R3: The serial clock is low whenever all select lines are high. While a select line is low, the clock makes exactly 10 rising edges, and each low phase and each high phase lasts HALF_CYCLES system cycles. The first low phase is the lead time after select falls.
- R4: The result is cleared at request time. The first clock pulse is a dummy. On each of clock pulses 2 to 9, the data line is sampled in the last system cycle of that pulse's low phase and shifted in from the low end, so the first bit sampled becomes bit 7 of the result.
- R5: After the tenth clock pulse the select line returns high, having been low for exactly 21*HALF_CYCLES system cycles.
- R6: Done rises exactly SETTLE_CYCLES cycles after the select line returns high, which is 21*HALF_CYCLES + SETTLE_CYCLES cycles after the clock edge that accepted the request. At that point all select lines are high.
- R7: Done is high for exactly one cycle, and the result output changes only in the cycle where done is high. It keeps its value until the next done.
- R8: A request made while busy is ignored: it neither changes the select line in use nor the result, and it does not cause a second read.
- R9: A request whose index is NUM_DEV or more is ignored: busy stays low, no select line goes low and no done follows.
- R10: Busy is high from the cycle after an accepted request up to the cycle before done, and low in the done cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Read request, sampled while idle |
| dev_sel_i | input | SEL_W | Index of the converter to read |
| sdat_i | input | 1 | Shared serial data from the converters |
| sclk_o | output | 1 | Shared serial clock to the converters |
| cs_n_o | output | NUM_DEV | Active-low select, one line per converter |
| busy_o | output | 1 | A read is in progress |
| done_o | output | 1 | One-cycle strobe; result is valid |
| data_o | output | 8 | Last byte read |

## Verification
The bench builds the block with NUM_DEV = 3, HALF_CYCLES = 2 and SETTLE_CYCLES = 5. Three converters make the index two bits wide, so index 3 is a real input value that is out of range, and the ignore rule for it can be tried. Short clock phases and a short quiet time keep each read near 48 cycles, so many random bytes and all three select lines are covered. The length of every clock phase is still measured, and the exact latency is compared with 21*2+5.

// File: rtl/adcrd_pkg.sv
`timescale 1ns/1ps
package adcrd_pkg;

    localparam int DATA_BITS = 8;
    localparam int PULSES    = DATA_BITS + 2;
    localparam int PIDX_W    = $clog2(PULSES + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_SETTLE
    } rd_state_e;

    // Pulses 1..DATA_BITS carry data; pulse 0 and the last one are dummies.
    function automatic logic carries_data(input logic [PIDX_W-1:0] idx);
        return (idx >= PIDX_W'(1)) && (idx <= PIDX_W'(DATA_BITS));
    endfunction

endpackage

// File: rtl/adcrd_timer.sv
`timescale 1ns/1ps
module adcrd_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - TW'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/adcrd_shifter.sv
`timescale 1ns/1ps
module adcrd_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          shift,
    input  logic          din,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= '0;
        else if (shift)
            q <= {q[DW-2:0], din};
    end
endmodule

// File: rtl/adcrd_cs_drive.sv
`timescale 1ns/1ps
module adcrd_cs_drive #(
    parameter int NUM_DEV = 4,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               engage,
    input  logic               release_all,
    input  logic [SEL_W-1:0]   sel,
    output logic [NUM_DEV-1:0] cs_n
);
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst || release_all)
                cs_n[i] <= 1'b1;
            else if (engage)
                cs_n[i] <= (sel != SEL_W'(i));
        end
    end
endmodule

// File: rtl/serial_adc_reader.sv
`timescale 1ns/1ps
module serial_adc_reader #(
    parameter int NUM_DEV       = 4,
    parameter int HALF_CYCLES   = 4,
    parameter int SETTLE_CYCLES = 16,
    parameter int SEL_W         = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [SEL_W-1:0]   dev_sel_i,
    input  logic               sdat_i,
    output logic               sclk_o,
    output logic [NUM_DEV-1:0] cs_n_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [7:0]         data_o
);
    import adcrd_pkg::*;

    localparam int MAXC = (HALF_CYCLES > SETTLE_CYCLES) ? HALF_CYCLES : SETTLE_CYCLES;
    localparam int TW   = $clog2(MAXC + 1);
    localparam logic [TW-1:0]     HALF_V   = TW'(HALF_CYCLES - 1);
    localparam logic [TW-1:0]     SETTLE_V = TW'(SETTLE_CYCLES - 1);
    localparam logic [SEL_W:0]    DEV_LIM  = (SEL_W + 1)'(NUM_DEV);
    localparam logic [PIDX_W-1:0] LAST_P   = PIDX_W'(PULSES - 1);

    rd_state_e            state;
    logic [PIDX_W-1:0]    pidx;
    logic                 sclk_q, done_q;
    logic [DATA_BITS-1:0] res_q, sh_q;

    logic          accept, sel_ok;
    logic          tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic          sh_shift, cs_release;

    assign sel_ok = ({1'b0, dev_sel_i} < DEV_LIM);
    assign accept = start_i && (state == ST_IDLE) && sel_ok;

    always_comb begin
        tmr_load   = 1'b0;
        tmr_val    = HALF_V;
        sh_shift   = 1'b0;
        cs_release = 1'b0;
        unique case (state)
            ST_IDLE:           tmr_load = accept;
            ST_LEAD, ST_HIGH:  tmr_load = tmr_exp;
            ST_LOW: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    sh_shift = carries_data(pidx);
                    if (pidx == LAST_P) begin
                        cs_release = 1'b1;
                        tmr_val    = SETTLE_V;
                    end
                end
            end
            ST_SETTLE:         tmr_load = 1'b0;
            default:           tmr_load = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            pidx   <= '0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (accept) begin
                    state <= ST_LEAD;
                    pidx  <= '0;
                end
                ST_LEAD: if (tmr_exp) begin
                    state  <= ST_HIGH;
                    sclk_q <= 1'b1;
                end
                ST_HIGH: if (tmr_exp) begin
                    state  <= ST_LOW;
                    sclk_q <= 1'b0;
                end
                ST_LOW: if (tmr_exp) begin
                    if (pidx == LAST_P) begin
                        state <= ST_SETTLE;
                    end else begin
                        pidx   <= pidx + PIDX_W'(1);
                        state  <= ST_HIGH;
                        sclk_q <= 1'b1;
                    end
                end
                ST_SETTLE: if (tmr_exp) begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                    res_q  <= sh_q;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    adcrd_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    adcrd_shifter #(.DW(DATA_BITS)) u_shift (
        .clk(clk), .rst(rst), .clr(accept), .shift(sh_shift), .din(sdat_i), .q(sh_q)
    );

    adcrd_cs_drive #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) u_cs (
        .clk(clk), .rst(rst), .engage(accept), .release_all(cs_release),
        .sel(dev_sel_i), .cs_n(cs_n_o)
    );

    assign sclk_o = sclk_q;
    assign busy_o = (state != ST_IDLE);
    assign done_o = done_q;
    assign data_o = res_q;
endmodule

// File: rtl/adcrd_checker.sv
`timescale 1ns/1ps
module adcrd_checker #(
    parameter int NUM_DEV = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               sclk_o,
    input logic [NUM_DEV-1:0] cs_n_o,
    input logic               busy_o,
    input logic               done_o,
    input logic [7:0]         data_o
);
    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (&cs_n_o)); // R2
    AST_ONE_CS_LOW: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n_o) <= 1); // R2
    AST_SCLK_FRAMED: assert property (@(posedge clk) disable iff (rst)
        (&cs_n_o) |-> !sclk_o); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(data_o)); // R7
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((&cs_n_o) && !busy_o)); // R6
endmodule

bind serial_adc_reader adcrd_checker #(.NUM_DEV(NUM_DEV)) u_adcrd_chk (
    .clk(clk), .rst(rst), .sclk_o(sclk_o), .cs_n_o(cs_n_o),
    .busy_o(busy_o), .done_o(done_o), .data_o(data_o)
);

// File: tb/serial_adc_reader_test.sv
`timescale 1ns/1ps
module serial_adc_reader_test;
    localparam int N = 3;
    localparam int H = 2;
    localparam int S = 5;
    localparam int SW = 2;
    localparam int LAT = 21 * H + S;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [SW-1:0] sel = '0;
    logic          sdata = 1'b0;
    logic          sclk, busy, done;
    logic [N-1:0]  cs_n;
    logic [7:0]    data;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    serial_adc_reader #(.NUM_DEV(N), .HALF_CYCLES(H), .SETTLE_CYCLES(S)) uut (
        .clk(clk), .rst(rst), .start_i(start), .dev_sel_i(sel), .sdat_i(sdata),
        .sclk_o(sclk), .cs_n_o(cs_n), .busy_o(busy), .done_o(done), .data_o(data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // converter model and line monitor
    logic [7:0] cur_val = '0;
    int act_dev = 0;
    int fall_cnt = 0, rise_cnt = 0, low_cyc = 0, run = 0;
    int cs_err = 0, sclk_err = 0, phase_err = 0, done_seen = 0;
    logic sclk_prev = 1'b0;
    logic all_high_prev = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (&cs_n) begin
                if (sclk) sclk_err++;
                fall_cnt = 0;
                sdata = 1'($urandom % 2);
            end else begin
                low_cyc++;
                for (int d = 0; d < N; d++)
                    if (d != act_dev && !cs_n[d]) cs_err++;
                if (all_high_prev) begin
                    run = 1;
                end else if (sclk != sclk_prev) begin
                    if (run != H) phase_err++;
                    run = 1;
                end else begin
                    run++;
                end
                if (sclk_prev && !sclk) begin
                    fall_cnt++;
                    if (fall_cnt >= 2 && fall_cnt <= 9)
                        sdata = cur_val[9 - fall_cnt];
                end
                if (!sclk_prev && sclk) rise_cnt++;
            end
            if (done) done_seen++;
        end
        sclk_prev = sclk;
        all_high_prev = &cs_n;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    logic [7:0] last_data = '0;

    task automatic do_read(input int dev, input logic [7:0] v, input bit poke);
        int n;
        bit got;
        chk(data == last_data, "R7", "result held before request", data, last_data);
        cur_val = v; act_dev = dev;
        low_cyc = 0; rise_cnt = 0; cs_err = 0; phase_err = 0; done_seen = 0;
        @(posedge clk); #1;
        sel = SW'(dev); start = 1'b1;
        n = 0; got = 0;
        while (!got && n < 2000) begin
            @(posedge clk); #1;
            n++;
            if (n == 1) begin
                start = 1'b0;
                chk(cs_n[dev] == 1'b0, "R2", "selected line low", cs_n[dev], 0);
            end
            if (n == 2) chk(busy == 1'b1, "R10", "busy during read", busy, 1);
            if (poke && n == 10) begin start = 1'b1; sel = SW'((dev + 1) % N); end
            if (poke && n == 11) start = 1'b0;
            if (done) got = 1;
        end
        chk(n == LAT + 1, "R6", "latency edges", n - 1, LAT);
        chk(data == v, "R4", "result byte", data, v);
        chk(busy == 1'b0, "R10", "busy in done cycle", busy, 0);
        chk(low_cyc == 21 * H, "R5", "select low cycles", low_cyc, 21 * H);
        chk(rise_cnt == 10, "R3", "clock pulses", rise_cnt, 10);
        chk(phase_err == 0, "R3", "phase length errors", phase_err, 0);
        chk(cs_err == 0, "R2", "foreign select lows", cs_err, 0);
        last_data = v;
        @(posedge clk); #1;
        chk(done == 1'b0, "R7", "done one cycle", done, 0);
        if (poke) begin
            repeat (30) @(posedge clk);
            #1;
            chk(done_seen == 1 && busy == 1'b0, "R8", "single read after busy request",
                done_seen, 1);
            chk(data == v, "R8", "result unchanged", data, v);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        chk(cs_n == '1, "R1", "select after reset", cs_n, 7);
        chk(sclk == 1'b0, "R1", "clock after reset", sclk, 0);
        chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset", busy + done, 0);
        chk(data == 8'h00, "R1", "result after reset", data, 0);

        do_read(0, 8'h00, 0);
        do_read(1, 8'hFF, 0);
        do_read(2, 8'h80, 1);
        do_read(0, 8'h01, 0);
        do_read(2, 8'hA5, 0);

        // R9: out-of-range index
        done_seen = 0; low_cyc = 0;
        @(posedge clk); #1;
        sel = 2'd3; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chk(busy == 1'b0, "R9", "busy after bad index", busy, 0);
        repeat (20) @(posedge clk);
        #1;
        chk(done_seen == 0 && low_cyc == 0, "R9", "no activity after bad index",
            done_seen + low_cyc, 0);
        chk(data == last_data, "R9", "result kept", data, last_data);

        for (int k = 0; k < 16; k++)
            do_read(int'($urandom % N), 8'($urandom), (k % 5) == 3);

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge rst);
        forever begin
            @(negedge clk);
            if (sclk_err != 0) begin
                chk(0, "R3", "clock high with no select", sclk_err, 0);
                sclk_err = 0;
            end
        end
    end
endmodule